// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Controller

This block is a synchronous controller for one synchronous buck stage. A single PWM input decides which of two gate-enable outputs is on: the high-side gate follows the PWM level and the low-side gate takes its complement. Between the two, the controller inserts a dead time in which both gates are off, and the length of that gap adapts to what the power stage reports.

Three already-digitised comparator flags arrive from the analog side: the switch node is below about 1 V, the low-side gate is below one sixth of the supply, and the supply is above its undervoltage threshold. When the high side turns off, the low side waits until the switch node has first been seen high and then has dropped below the 1 V flag. If the node never rose, a fixed delay is used instead, and a hard timeout turns the low side on regardless. When the low side turns off, the high side waits for the low-side gate flag and then a short fixed delay. An active-low disable input and an undervoltage condition both force the two gates off. All delays are given in nanoseconds and turned into clock cycles from a clock-period parameter.

Top module: `deadtime_ctrl`

## Requirements
- R1: Once a dead time has ended with the block enabled, `hs_on_o` equals the PWM level and `ls_on_o` its complement; a high-side rise only follows a cycle with PWM high, and a low-side rise only follows a cycle with PWM low.
- R2: `hs_on_o` and `ls_on_o` are never both 1 in the same cycle.
- R3: One clock edge after `out_dis_ni` is sampled low, both outputs are 0, and they stay 0 while it is low whatever `pwm_i` does.
- R4: All three flags pass through a two-flop synchronizer. After the high side turns off, if `sw_low_i` goes to 0 (node high) and later back to 1, the low side turns on at the third clock edge after `sw_low_i` returns to 1, provided that is before the fixed delay of R5 ends.
- R5: If `sw_low_i` stays 1 (node never seen high) after the high side turns off, the low side turns on FIX_CYC = ceil(FIX_DLY_NS / CLK_PERIOD_NS) cycles after the high side went low (8 cycles by default).
- R6: If the node was seen high but `sw_low_i` never returns to 1, the low side turns on TO_CYC = ceil(TO_DLY_NS / CLK_PERIOD_NS) cycles after the high side went low (10 by default).
- R7: On a PWM rise the low side turns off at the next edge; the high side turns on HS_CYC = ceil(HS_DLY_NS / CLK_PERIOD_NS) cycles after the synchronized `lsg_low_i` is first seen 1 (HS_CYC after low-side off when the flag is already 1; 2 more cycles when the flag rises at the low-side-off instant).
- R8: Three clock edges after `supply_ok_i` is sampled low, both outputs are 0 and stay 0 while it is low; on its return the block restarts as in R10, two cycles later because of the synchronizer.
- R9: A PWM edge during a pending wait cancels it: the block starts the opposite wait from zero, without turning on the output it was waiting for.
- R10: When the block becomes enabled it starts from both-off and applies the normal dead-time rule for the PWM level: high side after HS_CYC cycles (flag 1), or low side after FIX_CYC cycles (node flag 1).
- R11: While `rst_ni` is low, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwm_i | input | 1 | PWM command, high selects the high-side gate |
| out_dis_ni | input | 1 | Output disable, active low |
| sw_low_i | input | 1 | Switch node below 1 V flag (asynchronous) |
| lsg_low_i | input | 1 | Low-side gate below one sixth of supply flag (asynchronous) |
| supply_ok_i | input | 1 | Supply above undervoltage threshold flag (asynchronous) |
| hs_on_o | output | 1 | High-side gate enable |
| ls_on_o | output | 1 | Low-side gate enable |

## Verification
The bench builds the block with a 20 ns clock period and the default 150 ns, 190 ns and 40 ns delays, giving waits of 8, 10 and 2 cycles. These short windows make it possible to sweep the switch-node high time over every value that ends before the fixed delay, and the low-side gate release over several lags, each against an exact cycle count derived from the synchronizer depth. Cancellation in both wait directions, disable and undervoltage entry and exit, and the timeout all land within a few dozen cycles each.

// File: rtl/deadtime_pkg.sv
package deadtime_pkg;

  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,
    ST_HS      = 3'd1,
    ST_HL_WAIT = 3'd2,
    ST_LS      = 3'd3,
    ST_LH_WAIT = 3'd4
  } dt_state_e;

  function automatic int ns_to_cyc(input int ns, input int period_ns);
    return (ns + period_ns - 1) / period_ns;
  endfunction

endpackage

// File: rtl/dt_sync.sv
module dt_sync #(
  parameter int           W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] ff_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q <= {2{RST_VAL[i]}};
      else         ff_q <= {ff_q[0], d_i[i]};
    end
    assign q_o[i] = ff_q[1];
  end

endmodule

// File: rtl/dt_timer.sv
module dt_timer #(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  output logic [CW-1:0] cnt_o
);

  localparam logic [CW-1:0] CNT_MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_o <= '0;
    else if (clr_i)             cnt_o <= '0;
    else if (cnt_o != CNT_MAX)  cnt_o <= cnt_o + 1'b1;
  end

endmodule

// File: rtl/dt_fsm.sv
module dt_fsm
  import deadtime_pkg::*;
#(
  parameter int CW      = 4,
  parameter int FIX_CYC = 8,
  parameter int TO_CYC  = 10,
  parameter int HS_CYC  = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          pwm_i,
  input  logic          sw_low_i,
  input  logic          gate_low_i,
  input  logic [CW-1:0] cnt_i,
  output logic          cnt_clr_o,
  output logic          hs_o,
  output logic          ls_o
);

  localparam logic [CW-1:0] FIX_LAST = CW'(FIX_CYC - 1);
  localparam logic [CW-1:0] TO_LAST  = CW'(TO_CYC - 1);
  localparam logic [CW-1:0] HS_LAST  = CW'(HS_CYC - 1);

  dt_state_e state_q, state_d;
  logic      seen_q, seen_d;   // switch node observed high in this wait
  logic      ls_go;

  // low-side release: node fell after rising, fixed delay without a rise, or hard timeout
  assign ls_go = (seen_q && sw_low_i) || (!seen_q && cnt_i >= FIX_LAST) || (cnt_i >= TO_LAST);

  always_comb begin
    state_d   = state_q;
    seen_d    = seen_q;
    cnt_clr_o = 1'b0;
    if (!en_i) begin
      state_d   = ST_OFF;
      seen_d    = 1'b0;
      cnt_clr_o = 1'b1;
    end else begin
      case (state_q)
        ST_OFF: begin
          cnt_clr_o = 1'b1;
          seen_d    = 1'b0;
          state_d   = pwm_i ? ST_LH_WAIT : ST_HL_WAIT;
        end
        ST_HS: begin
          cnt_clr_o = 1'b1;
          seen_d    = 1'b0;
          if (!pwm_i) state_d = ST_HL_WAIT;
        end
        ST_HL_WAIT: begin
          if (pwm_i) begin
            state_d   = ST_LH_WAIT;
            cnt_clr_o = 1'b1;
            seen_d    = 1'b0;
          end else begin
            if (!sw_low_i) seen_d = 1'b1;
            if (ls_go) begin
              state_d   = ST_LS;
              cnt_clr_o = 1'b1;
            end
          end
        end
        ST_LS: begin
          cnt_clr_o = 1'b1;
          if (pwm_i) state_d = ST_LH_WAIT;
        end
        ST_LH_WAIT: begin
          if (!pwm_i) begin
            state_d   = ST_HL_WAIT;
            cnt_clr_o = 1'b1;
            seen_d    = 1'b0;
          end else if (!gate_low_i) begin
            cnt_clr_o = 1'b1;
          end else if (cnt_i >= HS_LAST) begin
            state_d   = ST_HS;
            cnt_clr_o = 1'b1;
          end
        end
        default: state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      seen_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      seen_q  <= seen_d;
    end
  end

  assign hs_o = (state_q == ST_HS);
  assign ls_o = (state_q == ST_LS);

endmodule

// File: rtl/deadtime_ctrl.sv
module deadtime_ctrl
  import deadtime_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 20,
  parameter int FIX_DLY_NS    = 150,
  parameter int TO_DLY_NS     = 190,
  parameter int HS_DLY_NS     = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwm_i,
  input  logic out_dis_ni,
  input  logic sw_low_i,
  input  logic lsg_low_i,
  input  logic supply_ok_i,
  output logic hs_on_o,
  output logic ls_on_o
);

  localparam int FIX_CYC = ns_to_cyc(FIX_DLY_NS, CLK_PERIOD_NS);
  localparam int TO_CYC  = ns_to_cyc(TO_DLY_NS, CLK_PERIOD_NS);
  localparam int HS_RAW  = ns_to_cyc(HS_DLY_NS, CLK_PERIOD_NS);
  localparam int HS_CYC  = (HS_RAW < 1) ? 1 : HS_RAW;
  localparam int CW      = $clog2(TO_CYC + 2);

  logic [2:0]    flag_s;
  logic [CW-1:0] cnt;
  logic          cnt_clr;

  // bit order: supply ok, gate low, node low; all clear in reset (not ok)
  dt_sync #(.W(3), .RST_VAL(3'b000)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({supply_ok_i, lsg_low_i, sw_low_i}),
    .q_o    (flag_s)
  );

  dt_timer #(.CW(CW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .cnt_o  (cnt)
  );

  dt_fsm #(
    .CW      (CW),
    .FIX_CYC (FIX_CYC),
    .TO_CYC  (TO_CYC),
    .HS_CYC  (HS_CYC)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (out_dis_ni && flag_s[2]),
    .pwm_i      (pwm_i),
    .sw_low_i   (flag_s[0]),
    .gate_low_i (flag_s[1]),
    .cnt_i      (cnt),
    .cnt_clr_o  (cnt_clr),
    .hs_o       (hs_on_o),
    .ls_o       (ls_on_o)
  );

endmodule

// File: rtl/deadtime_ctrl_chk.sv
module deadtime_ctrl_chk #(
  parameter int TO_CYC = 10
) (
  input logic clk_i,
  input logic rst_ni,
  input logic pwm_i,
  input logic out_dis_ni,
  input logic supply_ok_i,
  input logic hs_on_o,
  input logic ls_on_o
);

  logic [7:0] gap_q;
  logic       clean_q;

  // cycles since high side went off with PWM low, valid only without disable or undervoltage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q   <= '0;
      clean_q <= 1'b0;
    end else begin
      if (hs_on_o)                          clean_q <= 1'b1;
      else if (!out_dis_ni || !supply_ok_i) clean_q <= 1'b0;
      if (hs_on_o || ls_on_o || pwm_i)      gap_q <= '0;
      else if (gap_q != 8'hff)              gap_q <= gap_q + 8'd1;
    end
  end

  a_r2_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_on_o && ls_on_o));

  a_r3_disable_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_dis_ni |=> (!hs_on_o && !ls_on_o));

  a_r8_uvlo_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!supply_ok_i, 3) |-> (!hs_on_o && !ls_on_o));

  a_r1_hs_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_on_o) |-> $past(pwm_i));

  a_r1_ls_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ls_on_o) |-> !$past(pwm_i));

  a_r6_timeout_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ls_on_o) && clean_q) |-> (gap_q <= 8'(TO_CYC + 1)));

endmodule

bind deadtime_ctrl deadtime_ctrl_chk #(.TO_CYC(TO_CYC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pwm_i       (pwm_i),
  .out_dis_ni  (out_dis_ni),
  .supply_ok_i (supply_ok_i),
  .hs_on_o     (hs_on_o),
  .ls_on_o     (ls_on_o)
);

// File: tb/deadtime_ctrl_bench.sv
module deadtime_ctrl_bench;

  localparam int FIX = 8;   // ceil(150/20)
  localparam int TO  = 10;  // ceil(190/20)
  localparam int HSD = 2;   // ceil(40/20)

  logic clk = 1'b0;
  logic rst_n, pwm, dis_n, sw_low, lsg_low, sup_ok;
  logic hs_on, ls_on;

  int checks = 0;
  int fails = 0;
  int overlap = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  deadtime_ctrl #(
    .CLK_PERIOD_NS (20),
    .FIX_DLY_NS    (150),
    .TO_DLY_NS     (190),
    .HS_DLY_NS     (40)
  ) u_deadtime_ctrl (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .pwm_i       (pwm),
    .out_dis_ni  (dis_n),
    .sw_low_i    (sw_low),
    .lsg_low_i   (lsg_low),
    .supply_ok_i (sup_ok),
    .hs_on_o     (hs_on),
    .ls_on_o     (ls_on)
  );

  always @(negedge clk) if (hs_on && ls_on) overlap++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int k);
    repeat (k) @(negedge clk);
  endtask

  // negedges after the driving negedge until the target output is high
  task automatic measure(input bit want_hs, input int sw0_n, input int sw1_n,
                         input int lsg1_n, output int n);
    n = 0;
    for (int i = 1; i <= 60; i++) begin
      @(negedge clk);
      n = i;
      if (want_hs ? hs_on : ls_on) break;
      if (i == sw0_n)  sw_low = 1'b0;
      if (i == sw1_n)  sw_low = 1'b1;
      if (i == lsg1_n) lsg_low = 1'b1;
    end
  endtask

  task automatic to_hs();
    pwm = 1'b1;
    tick(12);
  endtask

  task automatic to_ls();
    pwm = 1'b0;
    tick(14);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 1'b0; pwm = 1'b0; dis_n = 1'b1; sw_low = 1'b1; lsg_low = 1'b1; sup_ok = 1'b1;
    tick(3);
    chk("R11 reset hs", int'(hs_on), 0);
    chk("R11 reset ls", int'(ls_on), 0);
    rst_n = 1'b1;
    tick(16);
    chk("R1 idle ls", int'(ls_on), 1);
    chk("R1 idle hs", int'(hs_on), 0);

    // R7: sweep the lag of the low-side gate flag
    for (int d = 0; d < 4; d++) begin
      to_ls();
      lsg_low = 1'b0;
      tick(3);
      pwm = 1'b1;
      measure(1'b1, -1, -1, 1 + d, n);
      chk($sformatf("R7 hs delay lag=%0d", d), n, d + 3 + HSD);
      tick(2);
      chk("R1 steady hs", int'(hs_on), 1);
      chk("R1 steady ls", int'(ls_on), 0);
    end

    // R5: node never rises
    to_hs();
    pwm = 1'b0;
    measure(1'b0, -1, -1, -1, n);
    chk("R5 fixed delay", n, FIX + 1);
    tick(2);
    chk("R1 steady ls after fall", int'(ls_on), 1);

    // R4: node high for h cycles, then below threshold
    for (int h = 1; h <= 4; h++) begin
      to_hs();
      pwm = 1'b0;
      measure(1'b0, 1, 1 + h, -1, n);
      chk($sformatf("R4 node rule high=%0d", h), n, h + 4);
      sw_low = 1'b1;
    end

    // R6: node rises and never falls
    to_hs();
    pwm = 1'b0;
    measure(1'b0, 1, -1, -1, n);
    chk("R6 timeout", n, TO + 1);
    sw_low = 1'b1;

    // R9: cancel during high-to-low wait
    to_hs();
    pwm = 1'b0;
    tick(3);
    chk("R9 still in wait ls", int'(ls_on), 0);
    pwm = 1'b1;
    measure(1'b1, -1, -1, -1, n);
    chk("R9 cancel to high", n, HSD + 1);
    chk("R9 ls stayed off", int'(ls_on), 0);

    // R9: cancel during low-to-high wait
    to_ls();
    lsg_low = 1'b0;
    tick(3);
    pwm = 1'b1;
    tick(2);
    chk("R9 hs held by gate flag", int'(hs_on), 0);
    pwm = 1'b0;
    measure(1'b0, -1, -1, -1, n);
    chk("R9 cancel to low", n, FIX + 1);
    lsg_low = 1'b1;
    tick(3);

    // R3 and R10: output disable
    to_hs();
    dis_n = 1'b0;
    tick(1);
    chk("R3 disable hs", int'(hs_on), 0);
    chk("R3 disable ls", int'(ls_on), 0);
    for (int i = 0; i < 6; i++) begin
      pwm = ~pwm;
      tick(1);
      chk("R3 held off", int'(hs_on | ls_on), 0);
    end
    pwm = 1'b1;
    tick(1);
    dis_n = 1'b1;
    measure(1'b1, -1, -1, -1, n);
    chk("R10 restart high", n, HSD + 1);
    dis_n = 1'b0;
    tick(2);
    pwm = 1'b0;
    tick(1);
    dis_n = 1'b1;
    measure(1'b0, -1, -1, -1, n);
    chk("R10 restart low", n, FIX + 1);

    // R8: undervoltage
    to_ls();
    sup_ok = 1'b0;
    tick(2);
    chk("R8 sync latency ls", int'(ls_on), 1);
    tick(1);
    chk("R8 uvlo ls", int'(ls_on), 0);
    chk("R8 uvlo hs", int'(hs_on), 0);
    for (int i = 0; i < 6; i++) begin
      pwm = ~pwm;
      tick(1);
      chk("R8 held off", int'(hs_on | ls_on), 0);
    end
    pwm = 1'b1;
    tick(1);
    sup_ok = 1'b1;
    measure(1'b1, -1, -1, -1, n);
    chk("R8 restart high", n, HSD + 3);

    tick(4);
    chk("R2 overlap cycles", overlap, 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule